// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer with RAS-Only Refresh

This block sits between a simple request port and an asynchronous 64K x 4 dynamic memory that takes its address over eight multiplexed pins. Each accepted request carries a 16-bit word address, a direction flag and, for writes, a 4-bit value. The controller splits the address into a row byte and a column byte. It produces the active-low row strobe, column strobe and write-enable waveforms, and it drives or releases the shared 4-bit data bus. All timing comes from integer clock-cycle parameters.

Once a row is open it stays open. A later request that falls in the same row costs only a column phase. A request that falls in another row first closes the open row for the precharge time. An interval timer asks for a refresh at a fixed period. The controller services that request with a row-strobe-only cycle on the next row of a wrapping 8-bit counter. While a request is in flight, the refresh waits for it to finish. Once the refresh is pending, it goes ahead of any new request.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and after reset, the memory strobes and the write enable are high (inactive), the data driver enable is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: For an access, the pins carry the row byte `req_addr[15:8]` when the row strobe falls and stay unchanged across that edge. The pins carry the column byte `req_addr[7:0]` when the column strobe falls, which comes at least T_RCD cycles after the row strobe fell.
- R3: A request to the row that is already open produces a column strobe pulse with no rise of the row strobe.
- R4: A request to a row other than the open one raises the row strobe for exactly T_RP cycles, then opens the new row.
- R5: For a write, the write enable goes low at least one cycle before the column strobe falls and stays low while it is low. The data bus carries `req_wdata` at the column strobe's falling edge, and that value is stored at the addressed word.
- R6: For a read, the write enable stays high and the controller's data driver is off. `rsp_valid` pulses for one cycle, and `rsp_rdata` then holds the word last written at that address.
- R7: A refresh is a row-strobe pulse during which the column strobe stays high. Successive refreshes present the rows 0, 1, 2, and so on up to 255, then wrap to 0.
- R8: A refresh starts once per REF_INTERVAL cycles. It may be delayed by at most one access in progress plus one precharge, so the gap between two refresh starts stays within REF_INTERVAL plus or minus 16 cycles under the bench timing.
- R9: `req_ready` is 0 during a refresh, during every precharge window (the first T_RP cycles after the row strobe rises) and while the column strobe is low. When a refresh and a request are both waiting, the refresh is served first.
- R10: The column strobe stays low for exactly T_CAS cycles. For a read, `rsp_valid` appears T_ACC cycles after the column strobe falls, sampled before the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_addr | input | 16 | Word address, row byte in the upper half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write value |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 4 | Read value |
| dram_a | output | 8 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | 4 | Shared data bus |
| dram_dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
The refresh timer and host traffic can collide. A refresh request can come due while an access is in flight, or in the same idle cycle that a new request is presented. The bench provokes this with a short refresh interval and a steady stream of random reads and writes, spread over four rows so that hits and misses both occur. It judges each refresh by its row sequence, its start spacing and `req_ready` staying low throughout. It judges each delayed access by correct strobe order and by read data that matches a shadow memory.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_REF
    } st_e;
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
    parameter int INTERVAL = 3125,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pend,
    output logic [ROW_W-1:0] row
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (ack) begin
            d.pend = 1'b0;
            d.row  = q.row + 1'b1;
        end
        if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
    assign row  = q.row;
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 4,
    parameter int T_RCD = 2,
    parameter int T_CAS = 3,
    parameter int T_RP  = 3,
    parameter int T_ACC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_we,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic          ref_pend,
    input  logic [AW/2-1:0] ref_row,
    output logic          ref_ack,
    output logic [AW/2-1:0] pin_a,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    input  logic [DW-1:0] dq_in
);
    localparam int PW    = AW / 2;
    localparam int T_REF = T_RCD + T_CAS;
    localparam int MAXC  = (T_REF > T_RP) ? T_REF : T_RP;
    localparam int CNTW  = $clog2(MAXC + 1);
    localparam logic [CNTW-1:0] C_RP  = CNTW'(T_RP - 1);
    localparam logic [CNTW-1:0] C_RCD = CNTW'(T_RCD - 1);
    localparam logic [CNTW-1:0] C_REF = CNTW'(T_REF - 1);
    localparam logic [CNTW-1:0] C_CAS = CNTW'(T_CAS - 1);
    localparam logic [CNTW-1:0] C_ACC = CNTW'(T_ACC - 1);

    typedef struct packed {
        st_e            st;
        st_e            after;
        logic [CNTW-1:0] cnt;
        logic           open;
        logic [PW-1:0]  orow;
        logic [PW-1:0]  a;
        logic [PW-1:0]  col;
        logic           wr;
        logic [DW-1:0]  wd;
        logic           rv;
        logic [DW-1:0]  rd;
    } seq_t;

    seq_t q, d;
    logic [PW-1:0] req_row;

    assign req_row = req_addr[AW-1:PW];

    always_comb begin
        d       = q;
        d.rv    = 1'b0;
        ref_ack = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_ack = 1'b1;
                    d.a     = ref_row;
                    d.after = ST_REF;
                    d.st    = ST_PRE;
                    d.cnt   = q.open ? C_RP : '0;
                    d.open  = 1'b0;
                end else if (req_valid) begin
                    d.col = req_addr[PW-1:0];
                    d.wr  = req_we;
                    d.wd  = req_wdata;
                    if (q.open && q.orow == req_row) begin
                        d.st = ST_COL;
                        d.a  = req_addr[PW-1:0];
                    end else begin
                        d.st    = ST_PRE;
                        d.after = ST_RCD;
                        d.cnt   = q.open ? C_RP : '0;
                        d.open  = 1'b0;
                        d.orow  = req_row;
                        d.a     = req_row;
                    end
                end
            end
            ST_PRE: begin
                if (q.cnt == '0) begin
                    d.st  = q.after;
                    d.cnt = (q.after == ST_RCD) ? C_RCD : C_REF;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    d.st = ST_COL;
                    d.a  = q.col;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                d.st  = ST_CAS;
                d.cnt = '0;
            end
            ST_CAS: begin
                if (!q.wr && q.cnt == C_ACC) begin
                    d.rv = 1'b1;
                    d.rd = dq_in;
                end
                if (q.cnt == C_CAS) begin
                    d.st   = ST_IDLE;
                    d.open = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_REF: begin
                if (q.cnt == '0) begin
                    d.st    = ST_PRE;
                    d.after = ST_IDLE;
                    d.cnt   = C_RP;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.after <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE) && !ref_pend;
    assign ras_n     = !((q.st == ST_IDLE && q.open) ||
                         q.st == ST_RCD || q.st == ST_COL ||
                         q.st == ST_CAS || q.st == ST_REF);
    assign cas_n     = (q.st != ST_CAS);
    assign we_n      = !(q.wr && (q.st == ST_COL || q.st == ST_CAS));
    assign dq_oe     = !we_n;
    assign dq_out    = q.wd;
    assign pin_a     = q.a;
    assign rsp_valid = q.rv;
    assign rsp_rdata = q.rd;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 4,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 3,
    parameter int T_RP         = 3,
    parameter int T_ACC        = 2,
    parameter int REF_INTERVAL = 3125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W/2-1:0] dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    inout  wire  [DATA_W-1:0] dram_dq,
    output logic              dram_dq_oe
);
    localparam int PIN_W = ADDR_W / 2;

    logic             ref_pend;
    logic             ref_ack;
    logic [PIN_W-1:0] ref_row;
    logic             oe;
    logic [DATA_W-1:0] dq_out;
    logic [DATA_W-1:0] dq_in;

    fpm_refresh_timer #(
        .INTERVAL(REF_INTERVAL),
        .ROW_W   (PIN_W)
    ) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .ack  (ref_ack),
        .pend (ref_pend),
        .row  (ref_row)
    );

    fpm_seq #(
        .AW   (ADDR_W),
        .DW   (DATA_W),
        .T_RCD(T_RCD),
        .T_CAS(T_CAS),
        .T_RP (T_RP),
        .T_ACC(T_ACC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_we   (req_we),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .ref_pend (ref_pend),
        .ref_row  (ref_row),
        .ref_ack  (ref_ack),
        .pin_a    (dram_a),
        .ras_n    (dram_ras_n),
        .cas_n    (dram_cas_n),
        .we_n     (dram_we_n),
        .dq_oe    (oe),
        .dq_out   (dq_out),
        .dq_in    (dq_in)
    );

    assign dram_dq    = oe ? dq_out : {DATA_W{1'bz}};
    assign dq_in      = dram_dq;
    assign dram_dq_oe = oe;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [PW-1:0] dram_a,
    input logic          dram_ras_n,
    input logic          dram_cas_n,
    input logic          dram_we_n,
    input logic          dram_dq_oe
);
    // R7
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    row_stable_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_a));

    // R5
    we_before_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R5
    write_bus_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !dram_we_n) |-> dram_dq_oe);

    // R10
    rdata_inside_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!dram_cas_n) && $past(dram_we_n)));

    // R9
    ready_not_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dram_cas_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.PW(ADDR_W / 2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .dram_a    (dram_a),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;
    localparam int T_RCD = 2;
    localparam int T_CAS = 3;
    localparam int T_RP  = 2;
    localparam int T_ACC = 2;
    localparam int RI    = 120;
    localparam int SLACK = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_addr = '0;
    logic req_we = 1'b0;
    logic [3:0] req_wdata = '0;
    logic rsp_valid;
    logic [3:0] rsp_rdata;
    logic [7:0] dram_a;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    wire  [3:0] dram_dq;

    logic drv_en = 1'b0;
    logic [3:0] drv_val = '0;
    assign dram_dq = drv_en ? drv_val : 4'bz;

    always #2.5 clk = ~clk;

    fpm_dram_ctrl #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_ACC(T_ACC),
        .REF_INTERVAL(RI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_dq(dram_dq), .dram_dq_oe(dram_dq_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk(input logic [7:0] r, input logic [7:0] c);
        return {r, c};
    endfunction

    // memory model and observers
    logic [3:0] dmem   [bit [15:0]];
    logic [3:0] shadow [bit [15:0]];
    int cyc = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    int ras_fall_cyc = -1000, ras_rise_cyc = -1000, cas_fall_cyc = -1000;
    int last_high = 0;
    int ras_rises = 0, cas_rises = 0;
    logic [7:0] row_lat = '0;
    bit cas_in_win = 0, rdy_in_win = 0;
    logic [7:0] exp_ref_row = '0;
    int ref_cnt = 0, last_ref_cyc = 0, cur_ref_fall = 0, collisions = 0;
    bit vld_at_fall = 0;
    logic [7:0] exp_row = '0, exp_col = '0;
    logic [3:0] exp_wd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_ras && !dram_ras_n) begin
                ras_fall_cyc = cyc;
                row_lat      = dram_a;
                cas_in_win   = 0;
                rdy_in_win   = 0;
                vld_at_fall  = req_valid;
                last_high    = cyc - ras_rise_cyc;
            end
            if (!dram_ras_n && req_ready) rdy_in_win = 1;
            if (p_cas && !dram_cas_n) begin
                cas_in_win   = 1;
                cas_fall_cyc = cyc;
                // R2
                chk(row_lat == exp_row, "R2 row", row_lat, exp_row);
                chk(dram_a == exp_col, "R2 col", dram_a, exp_col);
                chk(cyc - ras_fall_cyc >= T_RCD, "R2 rcd", cyc - ras_fall_cyc, T_RCD);
                if (!dram_we_n) begin
                    // R5
                    chk(!p_we, "R5 we early", p_we, 0);
                    chk(dram_dq == exp_wd, "R5 wdata", dram_dq, exp_wd);
                    dmem[{row_lat, dram_a}] = dram_dq;
                end else begin
                    // R6
                    chk(!dram_dq_oe, "R6 bus released", dram_dq_oe, 0);
                    drv_val = dmem.exists({row_lat, dram_a}) ? dmem[{row_lat, dram_a}] : 4'h0;
                    drv_en  = 1'b1;
                end
            end
            if (!dram_cas_n && !dram_we_n)
                chk(p_we == 1'b0 || p_cas, "R5 we held", dram_we_n, 0);
            if (!p_cas && dram_cas_n) begin
                // R10
                chk(cyc - cas_fall_cyc == T_CAS, "R10 cas width", cyc - cas_fall_cyc, T_CAS);
                drv_en = 1'b0;
                cas_rises++;
            end
            if (rsp_valid)
                chk(cyc - cas_fall_cyc == T_ACC, "R10 sample point", cyc - cas_fall_cyc, T_ACC);
            if (!p_ras && dram_ras_n) begin
                ras_rise_cyc = cyc;
                ras_rises++;
                if (!cas_in_win) begin
                    // R7 refresh row order
                    chk(row_lat == exp_ref_row, "R7 refresh row", row_lat, exp_ref_row);
                    exp_ref_row = exp_ref_row + 8'd1;
                    // R9 ready low during refresh
                    chk(!rdy_in_win, "R9 ready in refresh", rdy_in_win, 0);
                    // R8 spacing
                    cur_ref_fall = ras_fall_cyc;
                    if (ref_cnt == 0)
                        chk(cur_ref_fall <= RI + SLACK, "R8 first refresh", cur_ref_fall, RI);
                    else
                        chk(cur_ref_fall - last_ref_cyc <= RI + SLACK &&
                            cur_ref_fall - last_ref_cyc >= RI - SLACK,
                            "R8 refresh gap", cur_ref_fall - last_ref_cyc, RI);
                    if (vld_at_fall) collisions++;
                    last_ref_cyc = cur_ref_fall;
                    ref_cnt++;
                end
            end
            if (dram_ras_n && cyc - ras_rise_cyc < T_RP)
                chk(!req_ready, "R9 ready in precharge", req_ready, 0);
            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
            p_we  = dram_we_n;
        end
    end

    task automatic do_op(input logic [15:0] addr, input logic we, input logic [3:0] wd);
        bit was_open, hit;
        int rr0, cr0;
        exp_row = addr[15:8];
        exp_col = addr[7:0];
        exp_wd  = wd;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_we    = we;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        was_open = !dram_ras_n;
        hit      = was_open && (row_lat == addr[15:8]);
        rr0      = ras_rises;
        cr0      = cas_rises;
        @(negedge clk);
        req_valid = 1'b0;
        if (!we) begin
            while (!rsp_valid) @(negedge clk);
            // R6
            chk(rsp_rdata == shadow[addr], "R6 read data", rsp_rdata, shadow[addr]);
        end else begin
            shadow[addr] = wd;
        end
        while (cas_rises == cr0) @(negedge clk);
        if (hit) begin
            // R3
            chk(ras_rises == rr0, "R3 no ras rise on hit", ras_rises - rr0, 0);
        end else if (was_open) begin
            // R4
            chk(ras_rises == rr0 + 1, "R4 one ras rise", ras_rises - rr0, 1);
            chk(last_high == T_RP, "R4 precharge width", last_high, T_RP);
        end
    endtask

    logic [7:0] rows [4] = '{8'h00, 8'h3A, 8'hC5, 8'hFF};

    initial begin
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        // R1
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(!dram_dq_oe && !rsp_valid, "R1 oe/rsp in reset", {dram_dq_oe, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        chk(dram_ras_n && dram_cas_n, "R1 strobes after reset", {dram_ras_n, dram_cas_n}, 3);

        // directed corners
        do_op(16'h0000, 1'b1, 4'hA);
        do_op(16'h0000, 1'b0, 4'h0);
        do_op(16'h00FF, 1'b1, 4'h5);
        do_op(16'h00FF, 1'b0, 4'h0);
        do_op(16'hFFFF, 1'b1, 4'hF);
        do_op(16'h0000, 1'b0, 4'h0);
        do_op(16'hFFFF, 1'b0, 4'h0);
        do_op(16'hFF00, 1'b1, 4'h3);
        do_op(16'hFF00, 1'b0, 4'h0);

        // random traffic across four rows
        for (int i = 0; i < 600; i++) begin
            logic [15:0] ad;
            logic w;
            ad = mk(rows[$urandom_range(0, 3)], 8'($urandom_range(0, 15)));
            w  = $urandom_range(0, 1) == 1;
            if (!shadow.exists(ad)) w = 1'b1;
            do_op(ad, w, 4'($urandom));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        // idle until the refresh row counter has wrapped
        while (ref_cnt < 260) @(negedge clk);
        chk(ref_cnt >= 260, "R7 wrap reached", ref_cnt, 260);
        // a final access after wrap
        do_op(16'h3A07, 1'b1, 4'h9);
        do_op(16'h3A07, 1'b0, 4'h0);
        $display("refresh collisions with waiting requests: %0d", collisions);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule